// File: doc/BRIEF.md
# Cascadable LCD Column Driver Core

This block is the digital core of one column driver for a dot-matrix LCD panel. The panel has 240 column outputs per chip, and several identical chips share one 8-bit data bus. A chip that holds the chain token takes in one byte on each falling edge of the data shift clock. It places the byte into a 240-bit line buffer, using a one-hot byte pointer. When it nears the end of its buffer, it pulls its enable output low so that the next chip is ready to take over. Once the buffer is full, it stops on its own.

A falling edge of the line clock copies the buffer into the output latch. The same edge restarts the chain for the next line. Each output carries a 2-bit drive-level code, formed from its latched bit, the AC polarity input and a display-blank input. A direction input mirrors the column order and swaps which enable pin is the input and which is the output.

All inputs are synchronous to `clk`. Edges of the shift clock and the line clock are detected from registered copies, so each clock must stay at one level for at least one `clk` cycle. Drive voltages and pad circuitry are outside this block.

Top module: `lcd_col_core`

## Requirements
- R1: After reset, both enable outputs are high and every output code is 2'b00, given `pol` low and `blank_n` high.
- R2: Captured byte k (k = 0 for the first byte) fills line pixels 8k to 8k+7, with `din[0]` on pixel 8k. Pixel p drives `drv[2p+1:2p]` when `dir` is low.
- R3: While the chip is not armed, falling edges of `sclk` leave the line buffer unchanged.
- R4: A chip is armed in two ways. A falling edge of `lclk` arms it if its enable input is low. A falling edge of `sclk` arms an idle, not-yet-full chip if its enable input is low. The byte present on that arming `sclk` edge is not captured. Capture starts on the next `sclk` falling edge.
- R5: The enable output is still high after 28 captured bytes. It goes low after the 29th byte, which is 232 bits.
- R6: After 30 bytes the chip stops. Further `sclk` edges do not change the buffer until the next `lclk` falling edge.
- R7: The outputs change only after a falling edge of `lclk`. That edge copies the whole buffer to the output latch.
- R8: With `dir` high, output j shows pixel 239-j. In that mode `eio2_i` is the enable input and `eio1_o` is the enable output, while `eio2_o` stays high. With `dir` low, `eio1_i` is the enable input and `eio2_o` is the enable output, while `eio1_o` stays high.
- R9: With `blank_n` low, every output code is 2'b10 (middle level).
- R10: With `blank_n` high, an output code is 2'b00 when its latched bit equals `pol` and 2'b01 otherwise.
- R11: A falling edge of `lclk` returns the enable output to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Data shift clock; acts on its falling edge |
| lclk | input | 1 | Line clock; acts on its falling edge |
| dir | input | 1 | Direction: 0 normal, 1 mirrored with enable pins swapped |
| blank_n | input | 1 | Low forces all outputs to the middle level |
| pol | input | 1 | AC polarity |
| din | input | 8 | Display data byte |
| eio1_i | input | 1 | Enable pin 1 input value |
| eio2_i | input | 1 | Enable pin 2 input value |
| eio1_o | output | 1 | Enable pin 1 output value |
| eio2_o | output | 1 | Enable pin 2 output value |
| drv | output | 480 | Two-bit drive code per output, output j at [2j+1:2j] |

## Verification
The bench drives a chained load in which the enable input falls just before an `sclk` edge. A design that captured on the arming edge would shift the whole image by one byte. It checks the enable output after both 28 and 29 bytes, because an off-by-one pointer would release the next chip one byte early or one byte late. A byte sent after the buffer is full must not appear on the outputs; a design that wrapped its pointer would overwrite byte 0. Mirrored mode is checked for both the reversed pixel order and the swapped enable pins, and every combination of blank and polarity is compared against the full output vector.

// File: rtl/lcd_col_core.sv
module lcd_col_core #(
  parameter int NOUT      = 240,
  parameter int BW        = 8,
  parameter int LEAD_BITS = 232
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              lclk,
  input  logic              dir,
  input  logic              blank_n,
  input  logic              pol,
  input  logic [BW-1:0]     din,
  input  logic              eio1_i,
  input  logic              eio2_i,
  output logic              eio1_o,
  output logic              eio2_o,
  output logic [2*NOUT-1:0] drv
);
  localparam int NB   = NOUT / BW;
  localparam int LEAD = LEAD_BITS / BW;

  logic            sclk_q, lclk_q;
  logic            act, full, enout_n;
  logic [NB-1:0]   ptr;
  logic [NOUT-1:0] img, line;

  wire sfall = sclk_q & ~sclk;
  wire lfall = lclk_q & ~lclk;
  wire en_in = dir ? eio2_i : eio1_i;
  wire cap   = sfall & act;

  assign eio1_o = dir ? enout_n : 1'b1;
  assign eio2_o = dir ? 1'b1 : enout_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      lclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      lclk_q <= lclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      full    <= 1'b0;
      enout_n <= 1'b1;
      ptr     <= '0;
    end else if (lfall) begin
      act     <= ~en_in;
      full    <= 1'b0;
      enout_n <= 1'b1;
      ptr     <= NB'(1);
    end else if (cap) begin
      ptr <= ptr << 1;
      if (ptr[LEAD-1]) enout_n <= 1'b0;
      if (ptr[NB-1]) begin
        act  <= 1'b0;
        full <= 1'b1;
      end
    end else if (sfall && !act && !full && !en_in) begin
      act <= 1'b1;
      ptr <= NB'(1);
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              img[k*BW +: BW] <= '0;
      else if (cap && ptr[k])  img[k*BW +: BW] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     line <= '0;
    else if (lfall) line <= img;
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    logic b;
    assign b = dir ? line[NOUT-1-j] : line[j];
    assign drv[2*j +: 2] = !blank_n ? 2'b10 : ((b == pol) ? 2'b00 : 2'b01);
  end

  // R4
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ptr));
  // R6
  full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> (!act && !enout_n));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (sfall && !act) |=> $stable(img));
  // R5
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(enout_n) |-> $past(cap));
  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !lfall |=> $stable(line));
endmodule

// File: tb/sim_lcd_col_core.sv
module sim_lcd_col_core;
  logic clk = 0, rst_n = 0, sclk = 0, lclk = 0, dir = 0, blank_n = 1, pol = 0;
  logic [7:0] din = 0;
  logic eio1_i = 1, eio2_i = 1;
  logic eio1_o, eio2_o;
  logic [479:0] drv;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [239:0] imga, imgb;

  lcd_col_core u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .lclk(lclk), .dir(dir),
    .blank_n(blank_n), .pol(pol), .din(din), .eio1_i(eio1_i), .eio2_i(eio2_i),
    .eio1_o(eio1_o), .eio2_o(eio2_o), .drv(drv));

  always #5 clk = ~clk;

  // {blank_n, pol} combinations walked against one latched image
  localparam logic [1:0] VEC [4] = '{2'b10, 2'b11, 2'b00, 2'b01};

  function automatic logic [479:0] expect_drv(logic [239:0] img, logic d, logic p, logic bl);
    logic [479:0] r;
    for (int j = 0; j < 240; j++) begin
      logic b;
      b = d ? img[239-j] : img[j];
      r[2*j +: 2] = !bl ? 2'b10 : ((b == p) ? 2'b00 : 2'b01);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [479:0] act_v, logic [479:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic byte_clk(logic [7:0] d);
    din = d; sclk = 1;
    repeat (2) @(negedge clk);
    sclk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic line_clk();
    lclk = 1;
    repeat (2) @(negedge clk);
    lclk = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 30; k++) begin
      imga[8*k +: 8] = 8'((k*37 + 5) & 255);
      imgb[8*k +: 8] = 8'((k*91 + 17) & 255);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 drv", drv, '0);
    chk("R1 eio", {478'd0, eio1_o, eio2_o}, {478'd0, 2'b11});

    // full load, normal direction
    eio1_i = 0;
    line_clk();
    for (int k = 0; k < 30; k++) begin
      byte_clk(imga[8*k +: 8]);
      if (k == 27) chk("R5 after 28", {479'd0, eio2_o}, {479'd0, 1'b1});
      if (k == 28) chk("R5 after 29", {479'd0, eio2_o}, {479'd0, 1'b0});
    end
    byte_clk(8'hFF);
    chk("R7 no line edge", drv, '0);
    eio1_i = 1;
    line_clk();
    chk("R2 R6 image", drv, expect_drv(imga, 0, 0, 1));
    chk("R11 eio2 high", {479'd0, eio2_o}, {479'd0, 1'b1});

    // vector table: blank / polarity
    foreach (VEC[i]) begin
      blank_n = VEC[i][1]; pol = VEC[i][0];
      @(negedge clk);
      chk(VEC[i][1] ? "R10 level select" : "R9 blank", drv, expect_drv(imga, 0, VEC[i][0], VEC[i][1]));
    end
    blank_n = 1; pol = 0;

    // idle chip ignores data
    for (int k = 0; k < 5; k++) byte_clk(8'h3C);
    line_clk();
    chk("R3 idle ignore", drv, expect_drv(imga, 0, 0, 1));

    // chained arming via sclk edge, arming byte dropped
    eio1_i = 0;
    byte_clk(8'h5A);
    for (int k = 0; k < 30; k++) byte_clk(imgb[8*k +: 8]);
    byte_clk(8'hC3);
    eio1_i = 1;
    line_clk();
    chk("R4 chain arm", drv, expect_drv(imgb, 0, 0, 1));

    // mirrored direction
    dir = 1; eio2_i = 0;
    line_clk();
    for (int k = 0; k < 30; k++) begin
      byte_clk(imga[8*k +: 8]);
      if (k == 28) chk("R8 eio swap", {478'd0, eio1_o, eio2_o}, {478'd0, 2'b01});
    end
    eio2_i = 1;
    line_clk();
    chk("R8 mirror", drv, expect_drv(imga, 1, 0, 1));
    chk("R8 R11 eio idle", {478'd0, eio1_o, eio2_o}, {478'd0, 2'b11});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule